// File: doc/BRIEF.md
# Dual-Mode Debug Trace Recorder

This block captures a running history of debug events into an on-chip buffer of 128-bit lines. It has two sources. One is a retired-instruction record from a processor pipeline: opcode, word-aligned program counter, result or store operand, and trap, error and breakpoint flags. The other is a system-bus transfer record: address, data, the AHB control fields, the interrupt request and level, and the trap type. Every stored line also carries a free-running 30-bit timestamp, so that events can be put in order afterwards.

Two enable inputs select what is recorded. With only the instruction enable set, instruction records fill the whole buffer. With only the bus enable set, bus transfers fill it. With both set, the buffer is split in two. Instruction lines go to the lower half and bus lines to the upper half, and one of each can be stored in the same cycle. A freeze request from the breakpoint logic stops recording, keeps both write indices and raises a one-cycle interrupt. Software then reads the lines through a simple registered read port and clears the freeze to resume.

Top module: `dbg_trace_recorder`

## Requirements
- R1: During reset the timestamp, both write indices, the frozen flag and the interrupt output are all zero.
- R2: The timestamp `ts_o` increments by one every cycle and wraps at 30 bits. Every stored line holds in bits 125:96 the timestamp value of its write cycle.
- R3: An instruction line is packed as follows. Bit 127 is the breakpoint flag and bit 126 is the continuation flag, which is set only on the second and later beats of one multi-cycle instruction. Bits 95:64 hold the result or store operand, bits 63:34 hold PC[31:2], bit 33 is the trap flag, bit 32 is the error-mode flag and bits 31:0 hold the opcode.
- R4: A bus line is packed as follows. Bit 127 is the breakpoint flag and bit 126 is zero. IRL is at 95:92, the level at 91:88 and the trap type at 87:80. Then come write at 79, trans at 78:77, size at 76:74, burst at 73:71, master at 70:67, lock at 66 and resp at 65:64. Data is at 63:32 and the address at 31:0.
- R5: A bus line is written only when the bus enable is set, `hready_i` is 1 and `htrans_i` is 2 (NONSEQ) or 3 (SEQ). Instruction records are ignored while the instruction enable is clear.
- R6: With one source enabled, that source's index advances by one after each write and wraps over all 2^IDX_W lines.
- R7: With both enables set, the instruction index has its MSB held at 0 and the bus index has its MSB held at 1. Each index wraps within its own half.
- R8: With both enables set, an instruction record and an active bus transfer in the same cycle are both stored in that cycle.
- R9: A record presented in the same cycle as a freeze request is still stored. While frozen, nothing is stored and both indices hold their values.
- R10: `irq_o` pulses for exactly one cycle, in the cycle after a freeze request that arrives while the block is not frozen. A request while already frozen raises no pulse.
- R11: `freeze_clr_i` ends the frozen state and recording resumes the next cycle. A request in the same cycle as a clear wins.
- R12: `rd_data_o` shows, one cycle after `rd_addr_i` is set, the line stored at that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ins_en_i | input | 1 | Record instruction entries |
| bus_en_i | input | 1 | Record bus entries (both set: split buffer) |
| freeze_req_i | input | 1 | Freeze request from breakpoint logic |
| freeze_clr_i | input | 1 | Software clear of freeze |
| ins_valid_i | input | 1 | Instruction record present |
| ins_bp_i | input | 1 | Instruction breakpoint hit |
| ins_cont_i | input | 1 | Later beat of a multi-cycle instruction |
| ins_result_i | input | 32 | Result, store address or store data |
| ins_pc_i | input | 30 | PC[31:2] |
| ins_trap_i | input | 1 | Instruction trapped |
| ins_err_i | input | 1 | Instruction caused error mode |
| ins_opcode_i | input | 32 | Opcode |
| bus_bp_i | input | 1 | Bus breakpoint hit |
| irl_i | input | 4 | Interrupt request input |
| pil_i | input | 4 | Processor interrupt level |
| tt_i | input | 8 | Trap type |
| hwrite_i | input | 1 | Bus write |
| htrans_i | input | 2 | Bus transfer type |
| hsize_i | input | 3 | Bus size |
| hburst_i | input | 3 | Bus burst |
| hmaster_i | input | 4 | Bus master id |
| hmastlock_i | input | 1 | Locked transfer |
| hresp_i | input | 2 | Bus response |
| hready_i | input | 1 | Bus transfer completes |
| hdata_i | input | 32 | Read or write data |
| haddr_i | input | 32 | Bus address |
| rd_addr_i | input | IDX_W | Read address |
| rd_data_o | output | 128 | Registered read line |
| ins_idx_o | output | IDX_W | Next instruction write line |
| bus_idx_o | output | IDX_W | Next bus write line |
| ts_o | output | 30 | Timestamp |
| frozen_o | output | 1 | Recording frozen |
| irq_o | output | 1 | Freeze interrupt pulse |

## Verification
In split mode an instruction write and a bus write fall in the same cycle. The bench keeps both sources active on every cycle for longer than a half. It then reads back every line of both halves against a model, which shows whether either write was lost or landed in the wrong half. The second overlap is a freeze request in the same cycle as a record. The bench presents both together, expects that record stored and nothing after it, and then checks a clear in the same cycle as a new request, where the request must keep the block frozen.

// File: rtl/trc_pkg.sv
package trc_pkg;
    localparam int LINE_W = 128;
    localparam int TS_W   = 30;

    typedef logic [LINE_W-1:0] line_t;

    typedef struct packed {
        logic        bp;
        logic        cont;
        logic [31:0] result;
        logic [29:0] pc;
        logic        trap;
        logic        err;
        logic [31:0] opcode;
    } ins_rec_t;

    typedef struct packed {
        logic        bp;
        logic [3:0]  irl;
        logic [3:0]  pil;
        logic [7:0]  tt;
        logic        hwrite;
        logic [1:0]  htrans;
        logic [2:0]  hsize;
        logic [2:0]  hburst;
        logic [3:0]  hmaster;
        logic        hlock;
        logic [1:0]  hresp;
        logic [31:0] data;
        logic [31:0] addr;
    } bus_rec_t;

    typedef struct packed {
        logic            frozen;
        logic            irq;
        logic [TS_W-1:0] ts;
    } ctl_t;
endpackage

// File: rtl/trc_line_pack.sv
module trc_line_pack
    import trc_pkg::*;
(
    input  ins_rec_t        ins_i,
    input  bus_rec_t        bus_i,
    input  logic [TS_W-1:0] ts_i,
    output line_t           ins_line_o,
    output line_t           bus_line_o
);
    always_comb begin
        ins_line_o           = '0;
        ins_line_o[127]      = ins_i.bp;
        ins_line_o[126]      = ins_i.cont;
        ins_line_o[125:96]   = ts_i;
        ins_line_o[95:64]    = ins_i.result;
        ins_line_o[63:34]    = ins_i.pc;
        ins_line_o[33]       = ins_i.trap;
        ins_line_o[32]       = ins_i.err;
        ins_line_o[31:0]     = ins_i.opcode;

        bus_line_o           = '0;
        bus_line_o[127]      = bus_i.bp;
        bus_line_o[126]      = 1'b0;
        bus_line_o[125:96]   = ts_i;
        bus_line_o[95:92]    = bus_i.irl;
        bus_line_o[91:88]    = bus_i.pil;
        bus_line_o[87:80]    = bus_i.tt;
        bus_line_o[79]       = bus_i.hwrite;
        bus_line_o[78:77]    = bus_i.htrans;
        bus_line_o[76:74]    = bus_i.hsize;
        bus_line_o[73:71]    = bus_i.hburst;
        bus_line_o[70:67]    = bus_i.hmaster;
        bus_line_o[66]       = bus_i.hlock;
        bus_line_o[65:64]    = bus_i.hresp;
        bus_line_o[63:32]    = bus_i.data;
        bus_line_o[31:0]     = bus_i.addr;
    end
endmodule

// File: rtl/trc_index_ctr.sv
module trc_index_ctr #(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv_i,
    input  logic             split_i,
    input  logic             upper_i,
    output logic [IDX_W-1:0] idx_o
);
    localparam int LO_W = IDX_W - 1;

    logic [IDX_W-1:0] idx_d, idx_q, eff;

    always_comb begin
        eff   = split_i ? {upper_i, idx_q[LO_W-1:0]} : idx_q;
        idx_d = idx_q;
        if (adv_i) begin
            if (split_i) idx_d = {upper_i, eff[LO_W-1:0] + LO_W'(1)};
            else         idx_d = idx_q + IDX_W'(1);
        end
        idx_o = eff;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) idx_q <= '0;
        else        idx_q <= idx_d;
    end

    // R6
    full_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !split_i) |=> (idx_q == $past(idx_q) + IDX_W'(1)));

    // R7
    half_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && split_i) |=> (idx_q[IDX_W-1] == $past(upper_i)));
endmodule

// File: rtl/trc_store.sv
module trc_store
    import trc_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_a_i,
    input  logic [IDX_W-1:0] addr_a_i,
    input  line_t            data_a_i,
    input  logic             we_b_i,
    input  logic [IDX_W-1:0] addr_b_i,
    input  line_t            data_b_i,
    input  logic [IDX_W-1:0] rd_addr_i,
    output line_t            rd_data_o
);
    localparam int LO_W   = IDX_W - 1;
    localparam int BANK_D = 1 << LO_W;
    localparam int NB     = 2;

    line_t bank_rd [NB];
    line_t rd_d, rd_q;

    for (genvar b = 0; b < NB; b++) begin : g_bank
        localparam logic HI = 1'(b);
        line_t mem_q [BANK_D];
        logic  sel_a, sel_b;

        always_comb begin
            sel_a = we_a_i && (addr_a_i[IDX_W-1] == HI);
            sel_b = we_b_i && (addr_b_i[IDX_W-1] == HI);
        end

        always_ff @(posedge clk) begin
            if (sel_a)      mem_q[addr_a_i[LO_W-1:0]] <= data_a_i;
            else if (sel_b) mem_q[addr_b_i[LO_W-1:0]] <= data_b_i;
        end

        assign bank_rd[b] = mem_q[rd_addr_i[LO_W-1:0]];

        // R8
        bank_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(sel_a && sel_b));
    end

    always_comb rd_d = bank_rd[rd_addr_i[IDX_W-1]];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign rd_data_o = rd_q;
endmodule

// File: rtl/dbg_trace_recorder.sv
module dbg_trace_recorder
    import trc_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ins_en_i,
    input  logic              bus_en_i,
    input  logic              freeze_req_i,
    input  logic              freeze_clr_i,
    input  logic              ins_valid_i,
    input  logic              ins_bp_i,
    input  logic              ins_cont_i,
    input  logic [31:0]       ins_result_i,
    input  logic [31:2]       ins_pc_i,
    input  logic              ins_trap_i,
    input  logic              ins_err_i,
    input  logic [31:0]       ins_opcode_i,
    input  logic              bus_bp_i,
    input  logic [3:0]        irl_i,
    input  logic [3:0]        pil_i,
    input  logic [7:0]        tt_i,
    input  logic              hwrite_i,
    input  logic [1:0]        htrans_i,
    input  logic [2:0]        hsize_i,
    input  logic [2:0]        hburst_i,
    input  logic [3:0]        hmaster_i,
    input  logic              hmastlock_i,
    input  logic [1:0]        hresp_i,
    input  logic              hready_i,
    input  logic [31:0]       hdata_i,
    input  logic [31:0]       haddr_i,
    input  logic [IDX_W-1:0]  rd_addr_i,
    output logic [127:0]      rd_data_o,
    output logic [IDX_W-1:0]  ins_idx_o,
    output logic [IDX_W-1:0]  bus_idx_o,
    output logic [29:0]       ts_o,
    output logic              frozen_o,
    output logic              irq_o
);
    ctl_t     ctl_d, ctl_q;
    ins_rec_t ins_rec;
    bus_rec_t bus_rec;
    line_t    ins_line, bus_line;
    logic     split, bus_active, ins_we, bus_we;
    logic [IDX_W-1:0] ins_idx, bus_idx;

    always_comb begin
        ins_rec = '{bp: ins_bp_i, cont: ins_cont_i, result: ins_result_i,
                    pc: ins_pc_i, trap: ins_trap_i, err: ins_err_i,
                    opcode: ins_opcode_i};
        bus_rec = '{bp: bus_bp_i, irl: irl_i, pil: pil_i, tt: tt_i,
                    hwrite: hwrite_i, htrans: htrans_i, hsize: hsize_i,
                    hburst: hburst_i, hmaster: hmaster_i, hlock: hmastlock_i,
                    hresp: hresp_i, data: hdata_i, addr: haddr_i};
    end

    always_comb begin
        split      = ins_en_i && bus_en_i;
        bus_active = hready_i && htrans_i[1];
        ins_we     = ins_en_i && ins_valid_i && !ctl_q.frozen;
        bus_we     = bus_en_i && bus_active && !ctl_q.frozen;

        ctl_d      = ctl_q;
        ctl_d.ts   = ctl_q.ts + TS_W'(1);
        ctl_d.irq  = freeze_req_i && !ctl_q.frozen;
        if (freeze_req_i)      ctl_d.frozen = 1'b1;
        else if (freeze_clr_i) ctl_d.frozen = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    trc_line_pack i_pack (
        .ins_i      (ins_rec),
        .bus_i      (bus_rec),
        .ts_i       (ctl_q.ts),
        .ins_line_o (ins_line),
        .bus_line_o (bus_line)
    );

    trc_index_ctr #(.IDX_W(IDX_W)) i_ins_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv_i   (ins_we),
        .split_i (split),
        .upper_i (1'b0),
        .idx_o   (ins_idx)
    );

    trc_index_ctr #(.IDX_W(IDX_W)) i_bus_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv_i   (bus_we),
        .split_i (split),
        .upper_i (1'b1),
        .idx_o   (bus_idx)
    );

    trc_store #(.IDX_W(IDX_W)) i_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .we_a_i    (ins_we),
        .addr_a_i  (ins_idx),
        .data_a_i  (ins_line),
        .we_b_i    (bus_we),
        .addr_b_i  (bus_idx),
        .data_b_i  (bus_line),
        .rd_addr_i (rd_addr_i),
        .rd_data_o (rd_data_o)
    );

    assign ins_idx_o = ins_idx;
    assign bus_idx_o = bus_idx;
    assign ts_o      = ctl_q.ts;
    assign frozen_o  = ctl_q.frozen;
    assign irq_o     = ctl_q.irq;

    // R2
    ts_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (ctl_q.ts == $past(ctl_q.ts) + TS_W'(1)));

    // R9
    frozen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.frozen |=> (($stable(ins_idx) && $stable(bus_idx)) || !$stable(split)));

    // R10
    irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.irq |=> !ctl_q.irq);

    // R10
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.irq |-> (ctl_q.frozen && !$past(ctl_q.frozen)));
endmodule

// File: tb/test_dbg_trace_recorder.sv
module test_dbg_trace_recorder;
    localparam int IW = 4;
    localparam int NL = 1 << IW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic ins_en = 0, bus_en = 0, frz_req = 0, frz_clr = 0;
    logic ins_valid = 0, ins_bp = 0, ins_cont = 0, ins_trap = 0, ins_err = 0;
    logic [31:0] ins_result = 0, ins_opcode = 0;
    logic [31:2] ins_pc = 0;
    logic bus_bp = 0, hwrite = 0, hlock = 0, hready = 0;
    logic [3:0] irl = 0, pil = 0, hmaster = 0;
    logic [7:0] tt = 0;
    logic [1:0] htrans = 0, hresp = 0;
    logic [2:0] hsize = 0, hburst = 0;
    logic [31:0] hdata = 0, haddr = 0;
    logic [IW-1:0] rd_addr = 0;
    logic [127:0] rd_data;
    logic [IW-1:0] ins_idx, bus_idx;
    logic [29:0] ts;
    logic frozen, irq;

    dbg_trace_recorder #(.IDX_W(IW)) i_dbg_trace_recorder (
        .clk(clk), .rst_n(rst_n), .ins_en_i(ins_en), .bus_en_i(bus_en),
        .freeze_req_i(frz_req), .freeze_clr_i(frz_clr),
        .ins_valid_i(ins_valid), .ins_bp_i(ins_bp), .ins_cont_i(ins_cont),
        .ins_result_i(ins_result), .ins_pc_i(ins_pc), .ins_trap_i(ins_trap),
        .ins_err_i(ins_err), .ins_opcode_i(ins_opcode),
        .bus_bp_i(bus_bp), .irl_i(irl), .pil_i(pil), .tt_i(tt),
        .hwrite_i(hwrite), .htrans_i(htrans), .hsize_i(hsize), .hburst_i(hburst),
        .hmaster_i(hmaster), .hmastlock_i(hlock), .hresp_i(hresp),
        .hready_i(hready), .hdata_i(hdata), .haddr_i(haddr),
        .rd_addr_i(rd_addr), .rd_data_o(rd_data), .ins_idx_o(ins_idx),
        .bus_idx_o(bus_idx), .ts_o(ts), .frozen_o(frozen), .irq_o(irq)
    );

    int checks = 0, errors = 0;
    logic [127:0] mdl [NL];
    logic         mvalid [NL];
    logic [IW-1:0] s_ins = 0, s_bus = 0;
    logic e_frz = 0;
    logic e_irq = 0;

    task automatic chk(input logic ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [IW-1:0] eff(input logic [IW-1:0] s, input logic sp, input logic hi);
        return sp ? {hi, s[IW-2:0]} : s;
    endfunction

    function automatic logic [IW-1:0] nxt(input logic [IW-1:0] s, input logic sp, input logic hi);
        logic [IW-2:0] lo;
        lo = s[IW-2:0] + 1'b1;
        return sp ? {hi, lo} : s + 1'b1;
    endfunction

    task automatic set_stim(input int n);
        ins_bp = (n % 7) == 3;  ins_cont = (n % 3) != 0;
        ins_trap = n[0];        ins_err = n[1];
        ins_result = 32'h9E37_79B9 * n;  ins_opcode = 32'h8100_0000 ^ (n * 32'h0101_0311);
        ins_pc = 30'h0400_0000 + 30'(n);
        bus_bp = (n % 5) == 1;  irl = 4'(n);  pil = 4'(n + 3);  tt = 8'(n * 13);
        hwrite = n[2];          hsize = 3'(n);  hburst = 3'(n + 1);
        hmaster = 4'(n * 5);    hlock = n[3];   hresp = 2'(n + 2);
        hdata = 32'hC0DE_0000 + 32'(n * 7); haddr = 32'h4000_0000 + 32'(n * 4);
    endtask

    task automatic step();
        logic sp, iw, bw;
        logic [29:0] t;
        logic [IW-1:0] a;
        t  = ts;
        sp = ins_en && bus_en;
        iw = ins_en && ins_valid && !e_frz;
        bw = bus_en && hready && htrans[1] && !e_frz;
        if (iw) begin
            a = eff(s_ins, sp, 1'b0);
            mdl[a] = {ins_bp, ins_cont, t, ins_result, ins_pc, ins_trap, ins_err, ins_opcode};
            mvalid[a] = 1'b1;
            s_ins = nxt(s_ins, sp, 1'b0);
        end
        if (bw) begin
            a = eff(s_bus, sp, 1'b1);
            mdl[a] = {bus_bp, 1'b0, t, irl, pil, tt, hwrite, htrans, hsize, hburst,
                      hmaster, hlock, hresp, hdata, haddr};
            mvalid[a] = 1'b1;
            s_bus = nxt(s_bus, sp, 1'b1);
        end
        e_irq = frz_req && !e_frz;
        if (frz_req) e_frz = 1'b1; else if (frz_clr) e_frz = 1'b0;
        @(posedge clk); @(negedge clk);
        chk(ts == t + 30'd1, "R2 timestamp step", 128'(ts), 128'(t + 30'd1));
        chk(ins_idx == eff(s_ins, sp, 1'b0), "R6/R7 ins index", 128'(ins_idx), 128'(eff(s_ins, sp, 1'b0)));
        chk(bus_idx == eff(s_bus, sp, 1'b1), "R6/R7 bus index", 128'(bus_idx), 128'(eff(s_bus, sp, 1'b1)));
        chk(frozen == e_frz, "R9/R11 frozen flag", 128'(frozen), 128'(e_frz));
        chk(irq == e_irq, "R10 irq pulse", 128'(irq), 128'(e_irq));
    endtask

    task automatic readback(input string tag);
        ins_valid = 0; htrans = 2'd0;
        for (int a = 0; a < NL; a++) begin
            if (mvalid[a]) begin
                rd_addr = IW'(a);
                @(posedge clk); @(negedge clk);
                chk(rd_data === mdl[a], tag, rd_data, mdl[a]);
            end
        end
    endtask

    task automatic do_reset();
        ins_en = 0; bus_en = 0; frz_req = 0; frz_clr = 0; ins_valid = 0; htrans = 0; hready = 0;
        rst_n = 0;
        repeat (2) @(negedge clk);
        // R1
        chk(ts == 0 && ins_idx == 0 && bus_idx == 0 && !frozen && !irq,
            "R1 reset state", {ts, ins_idx, bus_idx, frozen, irq}, '0);
        rst_n = 1;
        s_ins = 0; s_bus = 0; e_frz = 0; e_irq = 0;
    endtask

    initial begin
        #2_000_000;
        errors++; checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int a = 0; a < NL; a++) mvalid[a] = 1'b0;
        @(negedge clk);
        do_reset();

        // R3 R6: instruction-only, wrap over all lines; bus activity ignored (R5)
        ins_en = 1; hready = 1;
        for (int n = 0; n < 20; n++) begin
            set_stim(n); ins_valid = (n % 4) != 2; htrans = 2'd2;
            step();
        end
        readback("R3 R12 instruction line");

        // R4 R5: bus-only sweep of htrans x hready; instruction records ignored
        do_reset();
        bus_en = 1;
        for (int n = 0; n < 80; n++) begin
            set_stim(n + 100); htrans = 2'(n % 4); hready = n[2]; ins_valid = 1;
            step();
        end
        readback("R4 R5 R12 bus line");

        // R7 R8: mixed mode, both sources every cycle
        do_reset();
        ins_en = 1; bus_en = 1; hready = 1;
        for (int n = 0; n < 12; n++) begin
            set_stim(n + 300); ins_valid = 1; htrans = 2'(2 + (n % 2));
            step();
        end
        readback("R7 R8 R12 split halves");

        // R9 R10 R11: freeze in mixed mode
        set_stim(400); ins_valid = 1; htrans = 2'd3; hready = 1; frz_req = 1;
        step();
        frz_req = 0;
        for (int n = 0; n < 3; n++) begin set_stim(401 + n); step(); end
        frz_req = 1; step();
        frz_req = 1; frz_clr = 1; step();
        frz_req = 0; frz_clr = 1; step();
        frz_clr = 0;
        for (int n = 0; n < 3; n++) begin set_stim(410 + n); step(); end
        readback("R9 R11 freeze contents");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule